// File: doc/BRIEF.md
# Direction-Reversing Ping-Pong Buffer

This block joins two streaming stages of a batched tridiagonal solver. The upstream stage (the ascending sweep) emits a group of `ROWS` rows. Each row holds `LANES` interleaved words, one per independent system, and rows arrive in ascending order. The downstream stage (the descending sweep) has to see the same group with the rows in descending order. Inside each row the lanes keep their order, so the words a consumer sees are still spaced `LANES` apart per system.

The block holds two storage banks. The writer fills one bank with ascending addresses. At the same time the reader drains the other bank, and it computes each read address as `(ROWS-1-row)*LANES + lane`. Each bank has a one-bit full flag. The writer sets the flag when the last word of a group lands. The reader clears it when the last word of that group leaves. Both sides count without a break over the whole run, so a bank swap costs no extra cycle when the other bank is ready.

The writer FSM has two states. `W_FILL` accepts words. It moves to `W_HOLD` when a group completes while the next bank is still full and is not being released in that cycle. `W_HOLD` returns to `W_FILL` when that bank is released. The reader FSM also has two states. `R_IDLE` moves to `R_DRAIN` when its bank is full or is being completed in that cycle. `R_DRAIN` returns to `R_IDLE` after the last word of a group, unless the other bank is already full or is being completed in that cycle.

Top module: `dir_rev_pingpong`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1 and `out_valid` is 0. Both flags are clear and both the writer and the reader point at bank 0.
- R2: Accepted words fill a group in ascending order. The word accepted at position `p` of a group (counted from 0) is row `p / LANES`, lane `p % LANES`.
- R3: Within a group, output position `q` carries the input word at position `(ROWS-1-q/LANES)*LANES + q%LANES`. Rows come out descending and lanes ascending.
- R4: `out_valid` stays 0 until all `ROWS*LANES` words of a group are accepted. It rises in the cycle after the last word is accepted.
- R5: While two complete groups are held and not yet fully drained, `in_ready` is 0. It returns to 1 in the cycle after the last word of the older group is taken.
- R6: There are no idle cycles at a swap. `in_ready` stays 1 across a group boundary if the other bank is free. `out_valid` stays 1 across a drain boundary if the other group is complete, or becomes complete in that same cycle.
- R7: Groups leave in the order they arrived. The two banks alternate on both sides.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | DATA_W | Upstream word, ascending row order |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DATA_W | Output word, descending row order |

## Verification
The bench builds the block with `ROWS=5`, `LANES=3` and `DATA_W=16`. These are non-power-of-two sizes, so the row-base arithmetic and counter wrap are tested at values a power-of-two build would hide. A 15-word group is short, so hundreds of swaps happen in a short run. Each input word is unique, so any misplaced row or lane shows up.

The phases are: continuous flow (zero-idle swaps), a long downstream stall (both banks full and the writer held), a drain with no input, and random valid/ready traffic. Random traffic makes a release and a commit land in the same cycle.

// File: rtl/dir_rev_pkg.sv
package dir_rev_pkg;
    typedef enum logic {
        W_FILL = 1'b0,
        W_HOLD = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_IDLE  = 1'b0,
        R_DRAIN = 1'b1
    } rd_state_e;
endpackage

// File: rtl/dir_rev_writer.sv
module dir_rev_writer
    import dir_rev_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           bank_full_i,
    input  logic                 rel_i,
    input  logic                 rel_bank_i,
    output logic                 we_o,
    output logic                 wbank_o,
    output logic [$clog2(ROWS*LANES)-1:0] waddr_o,
    output logic                 commit_o,
    output logic                 commit_bank_o
);
    localparam int DEPTH = ROWS * LANES;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    wr_state_e     state_q, state_d;
    logic          bank_q;
    logic [AW-1:0] cnt_q;
    logic          other_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_FILL;
            bank_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (we_o) begin
                if (cnt_q == LAST_ADDR) begin
                    cnt_q  <= '0;
                    bank_q <= ~bank_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        in_ready      = (state_q == W_FILL);
        we_o          = in_valid && in_ready;
        wbank_o       = bank_q;
        waddr_o       = cnt_q;
        commit_o      = we_o && (cnt_q == LAST_ADDR);
        commit_bank_o = bank_q;
        other_busy    = bank_full_i[~bank_q] && !(rel_i && rel_bank_i == ~bank_q);
        state_d       = state_q;
        unique case (state_q)
            W_FILL: if (commit_o && other_busy) state_d = W_HOLD;
            W_HOLD: if (!bank_full_i[bank_q] || (rel_i && rel_bank_i == bank_q))
                        state_d = W_FILL;
            default: state_d = W_FILL;
        endcase
    end

    // R5: a word is only ever written into a bank that is not marked full
    p_write_free_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> !bank_full_i[bank_q]);
endmodule

// File: rtl/dir_rev_reader.sv
module dir_rev_reader
    import dir_rev_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 out_valid,
    input  logic                 out_ready,
    input  logic [1:0]           bank_full_i,
    input  logic                 commit_i,
    input  logic                 commit_bank_i,
    output logic                 rbank_o,
    output logic [$clog2(ROWS*LANES)-1:0] raddr_o,
    output logic                 rel_o,
    output logic                 rel_bank_o
);
    localparam int DEPTH = ROWS * LANES;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [AW-1:0] TOP_BASE  = AW'((ROWS - 1) * LANES);
    localparam logic [AW-1:0] ROW_STEP  = AW'(LANES);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    rd_state_e     state_q, state_d;
    logic          bank_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] lane_q;
    logic          fire, last, here_ready, other_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            bank_q  <= 1'b0;
            base_q  <= TOP_BASE;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                if (lane_q == LAST_LANE) begin
                    lane_q <= '0;
                    if (base_q == '0) begin
                        base_q <= TOP_BASE;
                        bank_q <= ~bank_q;
                    end else begin
                        base_q <= base_q - ROW_STEP;
                    end
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        out_valid   = (state_q == R_DRAIN);
        fire        = out_valid && out_ready;
        last        = (base_q == '0) && (lane_q == LAST_LANE);
        rel_o       = fire && last;
        rel_bank_o  = bank_q;
        rbank_o     = bank_q;
        raddr_o     = base_q + AW'(lane_q);
        here_ready  = bank_full_i[bank_q] || (commit_i && commit_bank_i == bank_q);
        other_ready = bank_full_i[~bank_q] || (commit_i && commit_bank_i == ~bank_q);
        state_d     = state_q;
        unique case (state_q)
            R_IDLE:  if (here_ready) state_d = R_DRAIN;
            R_DRAIN: if (rel_o && !other_ready) state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    // R4: the reader only presents data from a bank whose group is complete
    p_drain_full_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_DRAIN) |-> bank_full_i[bank_q]);
endmodule

// File: rtl/dir_rev_banks.sv
module dir_rev_banks #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic                     wbank_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic                     rbank_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [DATA_W-1:0]        rdata_o
);
    logic [DATA_W-1:0] rd_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we_i && (wbank_i == 1'(b))) mem[waddr_i] <= wdata_i;
        end
        assign rd_word[b] = mem[raddr_i];
    end

    assign rdata_o = rd_word[rbank_i];
endmodule

// File: rtl/dir_rev_pingpong.sv
module dir_rev_pingpong #(
    parameter int DATA_W = 32,
    parameter int ROWS   = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int DEPTH = ROWS * LANES;
    localparam int AW    = $clog2(DEPTH);

    logic [1:0]    full_q;
    logic          we, wbank, commit, commit_bank;
    logic          rbank, rel, rel_bank;
    logic [AW-1:0] waddr, raddr;

    dir_rev_writer #(.ROWS(ROWS), .LANES(LANES)) writer_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .bank_full_i(full_q), .rel_i(rel), .rel_bank_i(rel_bank),
        .we_o(we), .wbank_o(wbank), .waddr_o(waddr),
        .commit_o(commit), .commit_bank_o(commit_bank)
    );

    dir_rev_reader #(.ROWS(ROWS), .LANES(LANES)) reader_i (
        .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
        .bank_full_i(full_q), .commit_i(commit), .commit_bank_i(commit_bank),
        .rbank_o(rbank), .raddr_o(raddr), .rel_o(rel), .rel_bank_o(rel_bank)
    );

    dir_rev_banks #(.DATA_W(DATA_W), .DEPTH(DEPTH)) banks_i (
        .clk(clk), .we_i(we), .wbank_i(wbank), .waddr_i(waddr), .wdata_i(in_data),
        .rbank_i(rbank), .raddr_i(raddr), .rdata_o(out_data)
    );

    for (genvar b = 0; b < 2; b++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                full_q[b] <= 1'b0;
            else if (commit && commit_bank == 1'(b))   full_q[b] <= 1'b1;
            else if (rel && rel_bank == 1'(b))         full_q[b] <= 1'b0;
        end
    end

    // R5: completion and release never target the same bank in one cycle
    p_flag_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rel) |-> (commit_bank != rel_bank));

    // R4: a released bank must have been marked full
    p_release_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> full_q[rel_bank]);

    // R8: a stalled output word holds
    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/dir_rev_pingpong_tb.sv
`timescale 1ns/1ps
module dir_rev_pingpong_tb_top;
    localparam int DATA_W = 16;
    localparam int ROWS   = 5;
    localparam int LANES  = 3;
    localparam int GRP    = ROWS * LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;

    always #2.5 clk = ~clk;

    dir_rev_pingpong #(.DATA_W(DATA_W), .ROWS(ROWS), .LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    int nvec = 0;
    int nfail = 0;
    logic [DATA_W-1:0] cur[$];
    logic [DATA_W-1:0] expq[$];
    int held = 0;
    int drained = 0;
    logic [DATA_W-1:0] seq = 16'h0100;
    logic prev_stall = 1'b0;
    logic [DATA_W-1:0] prev_data = '0;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        #1000000;
        nfail++;
        $display("FAIL watchdog: run did not finish (actual running, expected done)");
        summary();
        $finish;
    end

    // Compare the outputs with the model, then drive inputs and advance the model.
    task automatic step(input bit iv, input bit ordy);
        bit fin, fout;
        @(negedge clk);
        nvec++;
        if (in_ready !== (held < 2)) begin
            nfail++;
            $display("FAIL R1/R5/R6 in_ready: actual %0b expected %0b", in_ready, held < 2);
        end
        nvec++;
        if (out_valid !== (held > 0)) begin
            nfail++;
            $display("FAIL R1/R4/R6 out_valid: actual %0b expected %0b", out_valid, held > 0);
        end
        if (held > 0 && out_valid) begin
            nvec++;
            if (out_data !== expq[0]) begin
                nfail++;
                $display("FAIL R2/R3/R7 out_data: actual %h expected %h", out_data, expq[0]);
            end
        end
        if (prev_stall) begin
            nvec++;
            if (!out_valid || out_data !== prev_data) begin
                nfail++;
                $display("FAIL R8 hold: actual %h expected %h", out_data, prev_data);
            end
        end
        in_valid  = iv;
        out_ready = ordy;
        in_data   = seq;
        fin  = iv && in_ready;
        fout = ordy && out_valid;
        prev_stall = out_valid && !ordy;
        prev_data  = out_data;
        if (fout && expq.size() > 0) begin
            void'(expq.pop_front());
            drained++;
            if (drained == GRP) begin
                drained = 0;
                held--;
            end
        end
        if (fin) begin
            cur.push_back(seq);
            seq = seq + 1'b1;
            if (cur.size() == GRP) begin
                for (int q = 0; q < GRP; q++)
                    expq.push_back(cur[(ROWS - 1 - q / LANES) * LANES + q % LANES]);
                cur.delete();
                held++;
            end
        end
    endtask

    initial begin
        // R1: state while reset is held
        @(negedge clk);
        nvec++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: actual ready=%0b valid=%0b expected ready=1 valid=0",
                     in_ready, out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R6: continuous flow on both sides, swaps without bubbles
        for (int i = 0; i < 80; i++) step(1'b1, 1'b1);
        // R5: downstream stalls, both banks fill, writer held
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0);
        // R4/R7: drain with no input
        for (int i = 0; i < 50; i++) step(1'b0, 1'b1);
        // mixed traffic
        for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0));
        for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) != 0));
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1);
        summary();
        $finish;
    end
endmodule